// File: doc/BRIEF.md
# Multidrop Scan Slot-Address Selector

On a backplane where many scan bridges share one test bus, this block decides whether its own bridge takes part in later scan operations. The bridge's TAP controller drives three inputs into it: the Shift-IR and Update-IR state strobes and the Test-Logic-Reset strobe. While Shift-IR is active, the block takes in the last eight instruction bits from TDI. At Update-IR, if the bridge is idle, it reads that value as an address. It compares the address against the pin-strapped slot identification, with an optional mask that hides the low slot bits. It also recognises a set of special addresses: broadcast, interrogation, and a small range of multicast-group addresses.

When the address selects the bridge, the block raises `selected_o`. The TDO enable is granted only when exactly one bridge can answer, which means a unicast match. Interrogation also enables TDO and raises the acknowledge output, but the bridge does not become selected. Once the bridge is selected, each later Update-IR value goes downstream as an ordinary instruction. A dedicated release code ends the selection. An idle bridge treats every update as an address and forwards nothing.

Top module: `slot_select_top`

## Requirements
- R1: A nonzero, non-special address equal to `slot_id_i` sets `selected_o` = 1, `tdo_en_o` = 1 and `ack_o` = 0. The outputs change in the cycle after the clock edge that samples `upd_ir_i`.
- R2: A nonzero, non-special address that differs from the slot ID leaves all three outputs at 0.
- R3: Address 0x00 never selects the bridge and never enables TDO, even when the mask would make it compare equal.
- R4: With `addr_mask_i` = 1, bits [1:0] are excluded from the slot compare. With `addr_mask_i` = 0, all 8 bits must match.
- R5: Address 0xFF (broadcast) selects every bridge, with `tdo_en_o` = 0 and `ack_o` = 0.
- R6: Addresses 0xF0 to 0xF3 are multicast groups 0 to 3. Group g selects the bridge, with `tdo_en_o` = 0, only when bit g of the group register is 1. The group register loads `grp_d_i` on a clock edge with `grp_ld_i` = 1.
- R7: Address 0xFE (interrogation) gives `selected_o` = 0, `tdo_en_o` = 1 and `ack_o` = 1 until the next address update.
- R8: While the bridge is selected, each Update-IR value appears on `instr_o` with a one-cycle `instr_vld_o` pulse. The value 0xE5 instead clears the selection and produces no pulse.
- R9: While the bridge is not selected, an update never pulses `instr_vld_o`, and every updated value is decoded as an address.
- R10: `tap_tlr_i` clears the selection state. Either asynchronous reset (`rst_ni` or `trst_ni` low) clears the selection state and the group register.
- R11: The compare uses the last 8 bits shifted in, least significant bit first, whatever the length of the shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Device reset, active low, asynchronous |
| trst_ni | input | 1 | Test reset, active low, asynchronous |
| tap_tlr_i | input | 1 | TAP is in Test-Logic-Reset |
| shift_ir_i | input | 1 | TAP is in Shift-IR |
| upd_ir_i | input | 1 | TAP is in Update-IR |
| tdi_i | input | 1 | Serial test data in |
| slot_id_i | input | 8 | Strapped slot address |
| addr_mask_i | input | 1 | Hide low slot bits from the compare |
| grp_ld_i | input | 1 | Load the multicast group register |
| grp_d_i | input | 4 | Group membership bits |
| selected_o | output | 1 | Bridge is selected for scan operations |
| tdo_en_o | output | 1 | Bridge may drive shared TDO |
| ack_o | output | 1 | Interrogation acknowledge |
| instr_o | output | 8 | Instruction forwarded while selected |
| instr_vld_o | output | 1 | One-cycle strobe for `instr_o` |

## Verification
The bench sweeps all 256 addresses with the mask off and again with it on. It repeats the multicast codes under all 16 group-register patterns. A decoder that let the special codes or zero fall into the slot compare would select where it must not, and a mask that reached too many bits would accept neighbouring slots. Other sequences target an idle bridge that forwards instructions, a selected bridge that re-reads addresses or fails on the release code, and a compare window that takes the first bits shifted instead of the last. Interrogation must drive TDO without selecting the bridge, and broadcast must select it without driving TDO.

// File: rtl/slot_select_pkg.sv
package slot_select_pkg;
  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_UNI    = 3'd1,
    K_BCAST  = 3'd2,
    K_MCAST  = 3'd3,
    K_INTERR = 3'd4
  } sel_kind_e;
endpackage

// File: rtl/slot_addr_shift.sv
module slot_addr_shift #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          shift_i,
  input  logic          tdi_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)     sr_q <= '0;
    else if (shift_i) sr_q <= {tdi_i, sr_q[AW-1:1]};
  end

  assign addr_o = sr_q;
endmodule

// File: rtl/slot_addr_decode.sv
module slot_addr_decode
  import slot_select_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          MASK_W     = 2,
  parameter int          NGRP       = 4,
  parameter logic [AW-1:0] BCAST_A  = 8'hFF,
  parameter logic [AW-1:0] INTERR_A = 8'hFE,
  parameter logic [AW-1:0] MCAST_A  = 8'hF0
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [AW-1:0]   slot_i,
  input  logic            mask_en_i,
  input  logic [NGRP-1:0] grp_i,
  output sel_kind_e       kind_o
);
  localparam int GIW = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [AW-1:0] LOW_M = (AW)'((1 << MASK_W) - 1);

  logic          is_mc, is_special, slot_hit;
  logic [GIW-1:0] gidx;
  logic [AW-1:0] cmp_m;

  assign is_mc      = (addr_i[AW-1:GIW] == MCAST_A[AW-1:GIW]);
  assign gidx       = addr_i[GIW-1:0];
  assign is_special = is_mc || (addr_i == BCAST_A) || (addr_i == INTERR_A);
  assign cmp_m      = mask_en_i ? ~LOW_M : '1;
  assign slot_hit   = (((addr_i ^ slot_i) & cmp_m) == '0);

  always_comb begin
    kind_o = K_NONE;
    if (addr_i == '0)           kind_o = K_NONE;
    else if (addr_i == BCAST_A) kind_o = K_BCAST;
    else if (addr_i == INTERR_A) kind_o = K_INTERR;
    else if (is_mc)             kind_o = grp_i[gidx] ? K_MCAST : K_NONE;
    else if (!is_special && slot_hit) kind_o = K_UNI;
  end
endmodule

// File: rtl/slot_sel_ctrl.sv
module slot_sel_ctrl
  import slot_select_pkg::*;
#(
  parameter int            AW    = 8,
  parameter logic [AW-1:0] REL_A = 8'hE5
) (
  input  logic          clk_i,
  input  logic          arst_ni,
  input  logic          tlr_i,
  input  logic          upd_i,
  input  logic [AW-1:0] addr_i,
  input  sel_kind_e     hit_i,
  output sel_kind_e     kind_o,
  output logic [AW-1:0] instr_o,
  output logic          instr_vld_o
);
  sel_kind_e     kind_q;
  logic          sel_now;
  logic [AW-1:0] instr_q;
  logic          vld_q;

  assign sel_now = (kind_q == K_UNI) || (kind_q == K_BCAST) || (kind_q == K_MCAST);

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      kind_q  <= K_NONE;
      instr_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (tlr_i) begin
        kind_q <= K_NONE;
      end else if (upd_i) begin
        if (!sel_now) begin
          kind_q <= hit_i;
        end else if (addr_i == REL_A) begin
          kind_q <= K_NONE;
        end else begin
          instr_q <= addr_i;
          vld_q   <= 1'b1;
        end
      end
    end
  end

  assign kind_o      = kind_q;
  assign instr_o     = instr_q;
  assign instr_vld_o = vld_q;
endmodule

// File: rtl/slot_select_top.sv
module slot_select_top
  import slot_select_pkg::*;
#(
  parameter int AW     = 8,
  parameter int MASK_W = 2,
  parameter int NGRP   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trst_ni,
  input  logic            tap_tlr_i,
  input  logic            shift_ir_i,
  input  logic            upd_ir_i,
  input  logic            tdi_i,
  input  logic [AW-1:0]   slot_id_i,
  input  logic            addr_mask_i,
  input  logic            grp_ld_i,
  input  logic [NGRP-1:0] grp_d_i,
  output logic            selected_o,
  output logic            tdo_en_o,
  output logic            ack_o,
  output logic [AW-1:0]   instr_o,
  output logic            instr_vld_o
);
  logic            arst_n;
  logic [AW-1:0]   addr_q;
  logic [NGRP-1:0] grp_q;
  sel_kind_e       hit_kind, kind_q;

  assign arst_n = rst_ni & trst_ni;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)       grp_q <= '0;
    else if (grp_ld_i) grp_q <= grp_d_i;
  end

  slot_addr_shift #(.AW(AW)) u_shift (
    .clk_i   (clk_i),
    .arst_ni (arst_n),
    .shift_i (shift_ir_i),
    .tdi_i   (tdi_i),
    .addr_o  (addr_q)
  );

  slot_addr_decode #(.AW(AW), .MASK_W(MASK_W), .NGRP(NGRP)) u_dec (
    .addr_i    (addr_q),
    .slot_i    (slot_id_i),
    .mask_en_i (addr_mask_i),
    .grp_i     (grp_q),
    .kind_o    (hit_kind)
  );

  slot_sel_ctrl #(.AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .arst_ni     (arst_n),
    .tlr_i       (tap_tlr_i),
    .upd_i       (upd_ir_i),
    .addr_i      (addr_q),
    .hit_i       (hit_kind),
    .kind_o      (kind_q),
    .instr_o     (instr_o),
    .instr_vld_o (instr_vld_o)
  );

  assign selected_o = (kind_q == K_UNI) || (kind_q == K_BCAST) || (kind_q == K_MCAST);
  assign tdo_en_o   = (kind_q == K_UNI) || (kind_q == K_INTERR);
  assign ack_o      = (kind_q == K_INTERR);
endmodule

// File: rtl/slot_select_chk.sv
module slot_select_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          arst_n,
  input logic          tap_tlr_i,
  input logic          upd_ir_i,
  input logic [AW-1:0] addr_q,
  input logic          selected_o,
  input logic          tdo_en_o,
  input logic          ack_o,
  input logic          instr_vld_o
);
  AST_ZERO_NO_SELECT: assert property (@(posedge clk_i) disable iff (!arst_n)
    (upd_ir_i && !selected_o && addr_q == '0) |=> (!selected_o && !tdo_en_o)); // R3

  AST_TLR_CLEARS: assert property (@(posedge clk_i) disable iff (!arst_n)
    tap_tlr_i |=> (!selected_o && !tdo_en_o && !ack_o)); // R10

  AST_INSTR_WHEN_SELECTED: assert property (@(posedge clk_i) disable iff (!arst_n)
    instr_vld_o |-> $past(selected_o)); // R9

  AST_ACK_INTERROGATE: assert property (@(posedge clk_i) disable iff (!arst_n)
    ack_o |-> (tdo_en_o && !selected_o)); // R7

  AST_SELECT_ON_UPDATE: assert property (@(posedge clk_i) disable iff (!arst_n)
    $rose(selected_o) |-> $past(upd_ir_i)); // R1

  AST_HOLD_NO_UPDATE: assert property (@(posedge clk_i) disable iff (!arst_n)
    (!upd_ir_i && !tap_tlr_i) |=> $stable(selected_o)); // R8
endmodule

bind slot_select_top slot_select_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .arst_n      (arst_n),
  .tap_tlr_i   (tap_tlr_i),
  .upd_ir_i    (upd_ir_i),
  .addr_q      (addr_q),
  .selected_o  (selected_o),
  .tdo_en_o    (tdo_en_o),
  .ack_o       (ack_o),
  .instr_vld_o (instr_vld_o)
);

// File: tb/slot_select_top_test.sv
module slot_select_top_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, trst_n = 1'b1;
  logic tlr = 1'b0, shift = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic [7:0] slot = 8'h5A;
  logic mask = 1'b0, gld = 1'b0;
  logic [3:0] gd = 4'h0;
  logic sel, tdo_en, ack, ivld;
  logic [7:0] instr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [3:0] grp_model = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_select_top uut (
    .clk_i(clk), .rst_ni(rst_n), .trst_ni(trst_n), .tap_tlr_i(tlr),
    .shift_ir_i(shift), .upd_ir_i(upd), .tdi_i(tdi), .slot_id_i(slot),
    .addr_mask_i(mask), .grp_ld_i(gld), .grp_d_i(gd),
    .selected_o(sel), .tdo_en_o(tdo_en), .ack_o(ack),
    .instr_o(instr), .instr_vld_o(ivld)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic scan(logic [15:0] v, int n);
    for (int i = 0; i < n; i++) begin
      shift = 1'b1; tdi = v[i]; step();
    end
    shift = 1'b0; upd = 1'b1; step(); upd = 1'b0;
  endtask

  task automatic tlr_pulse();
    tlr = 1'b1; step(); tlr = 1'b0;
  endtask

  task automatic load_grp(logic [3:0] g);
    gd = g; gld = 1'b1; step(); gld = 1'b0; grp_model = g;
  endtask

  // expected {sel, tdo_en, ack} for an idle bridge
  function automatic logic [2:0] ref_out(logic [7:0] a, logic [7:0] s, logic m, logic [3:0] g);
    logic [7:0] cm;
    cm = m ? 8'hFC : 8'hFF;
    if (a == 8'h00) return 3'b000;
    if (a == 8'hFF) return 3'b100;
    if (a == 8'hFE) return 3'b011;
    if (a[7:2] == 6'b111100) return g[a[1:0]] ? 3'b100 : 3'b000;
    if (((a ^ s) & cm) == 8'h00) return 3'b110;
    return 3'b000;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h00) return "R3";
    if (a == 8'hFF) return "R5";
    if (a == 8'hFE) return "R7";
    if (a[7:2] == 6'b111100) return "R6";
    return "R1/R2";
  endfunction

  initial begin
    step(); step();
    check("R10 reset", {13'd0, sel, tdo_en, ack}, 16'd0);
    check("R10 reset vld", {15'd0, ivld}, 16'd0);
    rst_n = 1'b1; step();
    load_grp(4'b0101);

    // exact compare sweep
    mask = 1'b0;
    for (int a = 0; a < 256; a++) begin
      tlr_pulse(); scan(16'(a), 8);
      check(tag_of(8'(a)), {13'd0, sel, tdo_en, ack}, {13'd0, ref_out(8'(a), slot, 1'b0, grp_model)});
      check("R9 idle no instr", {15'd0, ivld}, 16'd0);
    end
    // masked compare sweep
    mask = 1'b1;
    for (int a = 0; a < 256; a++) begin
      tlr_pulse(); scan(16'(a), 8);
      check("R4 mask", {13'd0, sel, tdo_en, ack}, {13'd0, ref_out(8'(a), slot, 1'b1, grp_model)});
    end
    // zero address with slot that masks to zero
    slot = 8'h01; tlr_pulse(); scan(16'h0000, 8);
    check("R3 zero masked", {13'd0, sel, tdo_en, ack}, 16'd0);
    slot = 8'h5A; mask = 1'b0;

    // group patterns
    for (int g = 0; g < 16; g++) begin
      load_grp(4'(g));
      for (int m = 0; m < 4; m++) begin
        tlr_pulse(); scan(16'(8'hF0 + m), 8);
        check("R6 group", {13'd0, sel, tdo_en, ack}, {13'd0, ref_out(8'(8'hF0 + m), slot, 1'b0, grp_model)});
      end
    end

    // instruction forwarding and release
    tlr_pulse(); scan(16'h005A, 8);
    check("R1 select", {15'd0, sel}, 16'd1);
    scan(16'h003C, 8);
    check("R8 instr vld", {15'd0, ivld}, 16'd1);
    check("R8 instr val", {8'd0, instr}, 16'h003C);
    check("R8 still sel", {15'd0, sel}, 16'd1);
    step();
    check("R8 vld pulse", {15'd0, ivld}, 16'd0);
    scan(16'h00FE, 8);
    check("R8 special as instr", {13'd0, sel, tdo_en, ack}, 16'b110);
    scan(16'h00E5, 8);
    check("R8 release", {14'd0, sel, ivld}, 16'd0);
    scan(16'h00FF, 8);
    check("R9 addr after release", {14'd0, sel, ivld}, 16'b10);
    scan(16'h00E5, 8);
    scan(16'h00E5, 8);
    check("R9 idle release ignored", {14'd0, sel, ivld}, 16'd0);

    // long shift: last 8 bits count
    tlr_pulse(); scan(16'h5A00, 16);
    check("R11 last byte", {13'd0, sel, tdo_en, ack}, 16'b110);
    tlr_pulse(); scan(16'h005A, 16);
    check("R11 first byte ignored", {13'd0, sel, tdo_en, ack}, 16'd0);

    // TLR and async resets
    scan(16'h005A, 8);
    tlr_pulse();
    check("R10 tlr", {13'd0, sel, tdo_en, ack}, 16'd0);
    load_grp(4'b0001); scan(16'h005A, 8);
    trst_n = 1'b0; #1;
    check("R10 trst", {13'd0, sel, tdo_en, ack}, 16'd0);
    step(); trst_n = 1'b1; step();
    scan(16'h00F0, 8);
    check("R10 trst clears group", {15'd0, sel}, 16'd0);
    load_grp(4'b0001); scan(16'h00F0, 8);
    check("R6 group reloaded", {15'd0, sel}, 16'd1);
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    check("R10 rst", {13'd0, sel, tdo_en, ack}, 16'd0);
    scan(16'h00F0, 8);
    check("R10 rst clears group", {15'd0, sel}, 16'd0);

    summary();
  end
endmodule